// File: doc/BRIEF.md
# Output-Channel Parallel Dot-Product Array

The block is the arithmetic core of a convolution engine. It is a row of K processing elements, one for each output channel. Every cycle, each element multiplies a C-wide vector of signed feature values by a C-wide slice of its own filter and adds the result to a private accumulator. Feature vectors are not broadcast to the elements. A vector enters element 0 and is handed one register stage further down the row on each advancing cycle, together with its valid, first and last flags and its position index. Element k therefore works on a given vector k cycles after element 0 does.

A group of consecutive input vectors forms the sequence of filter positions for one output pixel. The upstream fetch logic marks the first vector of a group with `in_first` and the final one with `in_last`. When the last vector of a group reaches an element, that element emits its accumulated sum and clears the accumulator. Short delay lines line the K results up so that they leave as one word. The input side is a valid/ready stream. The output side is a valid/ready stream, and when the output is held it freezes the whole row. Filters are written through a simple addressed write port. Each entry is selected by element number and by position index.

Top module: `kdot_array`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `out_valid` is 0 and `in_ready` is 1. The accumulators and the position counter start from zero.
- R2: Feature element c sits at bits [c*W +: W] of `in_feat`, and weight c sits at bits [c*W +: W] of `flt_data`. Both are W-bit two's complement. For each vector, element k adds the sum over c of feature[c] * weight[k][pos][c].
- R3: Element k places the accumulated sum of a group in `out_data[k*AW +: AW]`. AW defaults to 2*W + clog2(C*MAXPOS), so a group of up to MAXPOS vectors cannot overflow.
- R4: The position index is 0 for the first vector accepted after reset, after a vector with `in_last`, and for any vector with `in_first`. Otherwise it is the previous index plus one. It selects the filter entry that is used.
- R5: A vector carrying `in_first` discards whatever partial sum the elements hold. The new group starts from that vector's product alone.
- R6: When `flt_we` is 1 at a clock edge, `flt_data` is stored as the weights of element `flt_pe` at position `flt_pos`. The store affects only products computed after that edge.
- R7: A cycle in which no vector is accepted leaves every accumulator unchanged. Input gaps do not alter any result.
- R8: If a vector with `in_last` is accepted at edge t and there is no back-pressure, `out_valid` is first high after edge t+K with that group's K results. Groups leave in the order they arrived.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold their values and no vector is accepted.
- R10: `in_ready` equals (not `out_valid`) or `out_ready`.
- R11: Element k+1 emits the result of a group on the advancing cycle that follows the emission by element k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Feature vector valid |
| in_ready | output | 1 | Array can accept a vector |
| in_feat | input | C*W | Signed feature vector, element c at [c*W +: W] |
| in_first | input | 1 | Vector starts a new group |
| in_last | input | 1 | Vector ends the current group |
| flt_we | input | 1 | Filter write strobe |
| flt_pe | input | max(1,clog2(K)) | Element selected for the filter write |
| flt_pos | input | max(1,clog2(MAXPOS)) | Position index selected for the filter write |
| flt_data | input | C*W | Signed filter weights, weight c at [c*W +: W] |
| out_valid | output | 1 | Result word valid |
| out_ready | input | 1 | Downstream accepts the result word |
| out_data | output | K*AW | Group sums, element k at [k*AW +: AW] |

## Verification
The assertions assume that upstream never sends a group longer than MAXPOS vectors. One property watches the run length of each group to enforce this, and the stimulus keeps every group, including aborted ones, at MAXPOS or fewer. The checks also assume that filter entries are rewritten only while the row is empty. The bench therefore loads filters only after draining the array with `out_ready` held high, and never during a stream. Stimulus mixes random input gaps, random output back-pressure, single-vector groups, groups aborted by `in_first`, and full-length groups of the most negative values. This keeps the run-length assumption intact while reaching the widest sums.

// File: rtl/kdot_pkg.sv
`timescale 1ns/1ps
package kdot_pkg;

   // Smallest accumulator width that holds MAXPOS positions of C signed
   // W x W products without wrapping.
   function automatic int acc_width_min(input int w, input int c, input int maxpos);
      return 2 * w + $clog2(c * maxpos);
   endfunction

   // Index width that never collapses to zero bits.
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/kdot_dot.sv
`timescale 1ns/1ps
// Combinational C-wide signed dot product, linear chain or balanced tree.
module kdot_dot #(
   parameter int C    = 4,
   parameter int W    = 8,
   parameter int AW   = 22,
   parameter bit TREE = 1'b1
) (
   input  logic [C*W-1:0]        feat,
   input  logic [C*W-1:0]        wgt,
   output logic signed [AW-1:0]  dot
);

   localparam int PW = 2 * W;
   localparam int NP = 1 << $clog2(C);

   logic signed [PW-1:0] prod [C];

   always_comb begin
      for (int c = 0; c < C; c++) begin
         prod[c] = $signed(feat[c*W +: W]) * $signed(wgt[c*W +: W]);
      end
   end

   generate
      if (TREE) begin : g_tree
         logic signed [AW-1:0] node [2*NP];
         always_comb begin
            for (int i = 0; i < 2 * NP; i++) begin
               node[i] = '0;
            end
            for (int i = 0; i < C; i++) begin
               node[NP + i] = AW'(prod[i]);
            end
            for (int i = NP - 1; i >= 1; i--) begin
               node[i] = node[2*i] + node[2*i + 1];
            end
         end
         assign dot = node[1];
      end else begin : g_chain
         always_comb begin
            dot = '0;
            for (int i = 0; i < C; i++) begin
               dot = dot + AW'(prod[i]);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/kdot_pe.sv
`timescale 1ns/1ps
// One processing element: private filter store, dot product, accumulator.
module kdot_pe #(
   parameter int C      = 4,
   parameter int W      = 8,
   parameter int AW     = 22,
   parameter int MAXPOS = 16,
   parameter int PSW    = 4,
   parameter bit TREE   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                adv,
   input  logic                s_vld,
   input  logic                s_first,
   input  logic                s_last,
   input  logic [PSW-1:0]      s_pos,
   input  logic [C*W-1:0]      s_feat,
   input  logic                wr_en,
   input  logic [PSW-1:0]      wr_pos,
   input  logic [C*W-1:0]      wr_data,
   output logic                em_vld,
   output logic [AW-1:0]       em_val,
   output logic [AW-1:0]       acc
);

   logic [C*W-1:0]       wmem [MAXPOS];
   logic [C*W-1:0]       wsel;
   logic signed [AW-1:0] dot;
   logic [AW-1:0]        base;
   logic [AW-1:0]        sum;

   always_ff @(posedge clk) begin
      if (wr_en) begin
         wmem[wr_pos] <= wr_data;
      end
   end

   assign wsel = wmem[s_pos];

   kdot_dot #(.C(C), .W(W), .AW(AW), .TREE(TREE)) u_dot (
      .feat (s_feat),
      .wgt  (wsel),
      .dot  (dot)
   );

   assign base = s_first ? '0 : acc;
   assign sum  = base + AW'(dot);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc    <= '0;
         em_vld <= 1'b0;
         em_val <= '0;
      end else if (adv) begin
         em_vld <= s_vld && s_last;
         if (s_vld) begin
            if (s_last) begin
               em_val <= sum;
               acc    <= '0;
            end else begin
               acc    <= sum;
            end
         end
      end
   end

endmodule

// File: rtl/kdot_skew.sv
`timescale 1ns/1ps
// Advance-gated delay line that lines element results up with the last one.
module kdot_skew #(
   parameter int AW    = 22,
   parameter int DEPTH = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic [AW-1:0] d,
   output logic [AW-1:0] q
);

   generate
      if (DEPTH == 0) begin : g_pass
         assign q = d;
      end else begin : g_line
         logic [AW-1:0] line [DEPTH];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) begin
                  line[i] <= '0;
               end
            end else if (adv) begin
               line[0] <= d;
               for (int i = 1; i < DEPTH; i++) begin
                  line[i] <= line[i-1];
               end
            end
         end
         assign q = line[DEPTH-1];
      end
   endgenerate

endmodule

// File: rtl/kdot_array.sv
`timescale 1ns/1ps
module kdot_array
   import kdot_pkg::*;
#(
   parameter int C      = 4,
   parameter int K      = 4,
   parameter int W      = 8,
   parameter int MAXPOS = 16,
   parameter int AW     = acc_width_min(W, C, MAXPOS),
   parameter bit TREE   = 1'b1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             in_valid,
   output logic                             in_ready,
   input  logic [C*W-1:0]                   in_feat,
   input  logic                             in_first,
   input  logic                             in_last,
   input  logic                             flt_we,
   input  logic [idx_width(K)-1:0]          flt_pe,
   input  logic [idx_width(MAXPOS)-1:0]     flt_pos,
   input  logic [C*W-1:0]                   flt_data,
   output logic                             out_valid,
   input  logic                             out_ready,
   output logic [K*AW-1:0]                  out_data
);

   localparam int PSW = idx_width(MAXPOS);
   localparam int KSW = idx_width(K);

   generate
      if (C < 1)      begin : g_bad_c   $error("C must be at least 1");      end
      if (K < 1)      begin : g_bad_k   $error("K must be at least 1");      end
      if (W < 2)      begin : g_bad_w   $error("W must be at least 2");      end
      if (MAXPOS < 1) begin : g_bad_mp  $error("MAXPOS must be at least 1"); end
      if (AW < acc_width_min(W, C, MAXPOS)) begin : g_bad_aw
         $error("AW too narrow for MAXPOS positions");
      end
   endgenerate

   logic                 adv;
   logic [PSW-1:0]       pos_ctr;
   logic [PSW-1:0]       pos_in;

   logic [K-1:0]         stg_vld;
   logic [K-1:0]         stg_first;
   logic [K-1:0]         stg_last;
   logic [PSW-1:0]       stg_pos  [K];
   logic [C*W-1:0]       stg_feat [K];

   logic [K-1:0]         em_vld;
   logic [AW-1:0]        em_val   [K];
   logic [AW-1:0]        res      [K];
   logic [K*AW-1:0]      acc_all;

   assign adv      = !out_valid || out_ready;
   assign in_ready = adv;
   assign pos_in   = in_first ? '0 : pos_ctr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_ctr <= '0;
      end else if (adv && in_valid) begin
         pos_ctr <= in_last ? '0 : pos_in + 1'b1;
      end
   end

   generate
      for (genvar k = 0; k < K; k++) begin : g_pe
         logic          src_vld;
         logic          src_first;
         logic          src_last;
         logic [PSW-1:0] src_pos;
         logic [C*W-1:0] src_feat;
         logic [AW-1:0]  acc_k;

         if (k == 0) begin : g_head
            assign src_vld   = in_valid;
            assign src_first = in_first;
            assign src_last  = in_last;
            assign src_pos   = pos_in;
            assign src_feat  = in_feat;
         end else begin : g_link
            assign src_vld   = stg_vld[k-1];
            assign src_first = stg_first[k-1];
            assign src_last  = stg_last[k-1];
            assign src_pos   = stg_pos[k-1];
            assign src_feat  = stg_feat[k-1];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stg_vld[k]   <= 1'b0;
               stg_first[k] <= 1'b0;
               stg_last[k]  <= 1'b0;
               stg_pos[k]   <= '0;
               stg_feat[k]  <= '0;
            end else if (adv) begin
               stg_vld[k]   <= src_vld;
               stg_first[k] <= src_first;
               stg_last[k]  <= src_last;
               stg_pos[k]   <= src_pos;
               stg_feat[k]  <= src_feat;
            end
         end

         kdot_pe #(
            .C(C), .W(W), .AW(AW), .MAXPOS(MAXPOS), .PSW(PSW), .TREE(TREE)
         ) u_pe (
            .clk     (clk),
            .rst_n   (rst_n),
            .adv     (adv),
            .s_vld   (stg_vld[k]),
            .s_first (stg_first[k]),
            .s_last  (stg_last[k]),
            .s_pos   (stg_pos[k]),
            .s_feat  (stg_feat[k]),
            .wr_en   (flt_we && (flt_pe == KSW'(k))),
            .wr_pos  (flt_pos),
            .wr_data (flt_data),
            .em_vld  (em_vld[k]),
            .em_val  (em_val[k]),
            .acc     (acc_k)
         );

         assign acc_all[k*AW +: AW] = acc_k;

         kdot_skew #(.AW(AW), .DEPTH(K - 1 - k)) u_skew (
            .clk   (clk),
            .rst_n (rst_n),
            .adv   (adv),
            .d     (em_val[k]),
            .q     (res[k])
         );

         assign out_data[k*AW +: AW] = res[k];
      end
   endgenerate

   assign out_valid = em_vld[K-1];

endmodule

// File: rtl/kdot_array_chk.sv
`timescale 1ns/1ps
module kdot_array_chk #(
   parameter int K      = 4,
   parameter int AW     = 22,
   parameter int MAXPOS = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic            in_ready,
   input logic            in_first,
   input logic            in_last,
   input logic            out_valid,
   input logic            out_ready,
   input logic [K*AW-1:0] out_data,
   input logic            adv,
   input logic [K-1:0]    stg_vld,
   input logic [K-1:0]    em_vld,
   input logic [K*AW-1:0] acc_all
);

   int run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= 0;
      end else if (in_valid && in_ready) begin
         run <= in_last ? 0 : (in_first ? 1 : run + 1);
      end
   end

   // R3: input assumption, groups never exceed MAXPOS vectors
   p_group_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !in_first) |-> (run < MAXPOS));

   p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!out_valid && in_ready));

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

   generate
      for (genvar k = 0; k < K; k++) begin : g_k
         p_acc_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !(adv && stg_vld[k]) |=> $stable(acc_all[k*AW +: AW]));
         if (k < K - 1) begin : g_sk
            p_skew_r11: assert property (@(posedge clk) disable iff (!rst_n)
               (adv && em_vld[k]) |=> em_vld[k+1]);
         end
      end
   endgenerate

endmodule

bind kdot_array kdot_array_chk #(.K(K), .AW(AW), .MAXPOS(MAXPOS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_first  (in_first),
   .in_last   (in_last),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .adv       (adv),
   .stg_vld   (stg_vld),
   .em_vld    (em_vld),
   .acc_all   (acc_all)
);

// File: tb/kdot_array_tb.sv
`timescale 1ns/1ps
module kdot_array_tb;

   localparam int C      = 4;
   localparam int K      = 4;
   localparam int W      = 8;
   localparam int MAXPOS = 16;
   localparam int AW     = 2 * W + $clog2(C * MAXPOS);
   localparam int KSW    = $clog2(K);
   localparam int PSW    = $clog2(MAXPOS);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [C*W-1:0]    in_feat = '0;
   logic              in_first = 1'b0;
   logic              in_last = 1'b0;
   logic              flt_we = 1'b0;
   logic [KSW-1:0]    flt_pe = '0;
   logic [PSW-1:0]    flt_pos = '0;
   logic [C*W-1:0]    flt_data = '0;
   logic              out_valid;
   logic              out_ready = 1'b1;
   logic [K*AW-1:0]   out_data;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   kdot_array u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_feat(in_feat), .in_first(in_first), .in_last(in_last),
      .flt_we(flt_we), .flt_pe(flt_pe), .flt_pos(flt_pos), .flt_data(flt_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
   );

   // ---------------- behavioural reference ----------------
   logic [C*W-1:0]  m_wt  [K][MAXPOS];
   longint          m_acc [K];
   int              m_pos;
   logic            m_v   [K+1];
   logic [K*AW-1:0] m_d   [K+1];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pos = 0;
         for (int k = 0; k < K; k++) m_acc[k] = 0;
         for (int j = 0; j <= K; j++) begin m_v[j] = 1'b0; m_d[j] = '0; end
      end else begin
         logic            adv_m;
         logic            nv;
         logic [K*AW-1:0] nd;
         adv_m = !m_v[K] || out_ready;
         if (adv_m) begin
            nv = 1'b0;
            nd = '0;
            if (in_valid) begin
               int p;
               p = in_first ? 0 : m_pos;
               for (int k = 0; k < K; k++) begin
                  longint s;
                  s = in_first ? 0 : m_acc[k];
                  for (int c = 0; c < C; c++)
                     s += $signed(in_feat[c*W +: W]) * $signed(m_wt[k][p][c*W +: W]);
                  if (in_last) begin
                     nd[k*AW +: AW] = AW'(s);
                     m_acc[k] = 0;
                  end else begin
                     m_acc[k] = s;
                  end
               end
               m_pos = in_last ? 0 : p + 1;
               nv = in_last;
            end
            for (int j = K; j >= 1; j--) begin m_v[j] = m_v[j-1]; m_d[j] = m_d[j-1]; end
            m_v[0] = nv;
            m_d[0] = nd;
         end
         if (flt_we) m_wt[flt_pe][flt_pos] = flt_data;
      end
   end

   // ---------------- per-clock comparison ----------------
   always @(negedge clk) begin
      #1;
      if (!rst_n) begin
         n_chk++;
         if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            n_bad++;
            $display("FAIL R1 reset state: out_valid=%b in_ready=%b expected 0/1", out_valid, in_ready);
         end
      end else begin
         n_chk++;
         if (in_ready !== (!m_v[K] || out_ready)) begin
            n_bad++;
            $display("FAIL R10 in_ready=%b expected %b", in_ready, (!m_v[K] || out_ready));
         end
         if (out_valid !== m_v[K]) begin
            n_bad++;
            $display("FAIL R8 out_valid=%b expected %b", out_valid, m_v[K]);
         end else if (m_v[K] && out_data !== m_d[K]) begin
            n_bad++;
            $display("FAIL R2/R3 out_data=%h expected %h", out_data, m_d[K]);
         end
      end
   end

   // ---------------- stimulus ----------------
   int gap_pct = 0;
   int bp_pct  = 0;

   function automatic logic [C*W-1:0] rnd_vec();
      logic [C*W-1:0] v;
      for (int c = 0; c < C; c++) v[c*W +: W] = W'($urandom);
      return v;
   endfunction

   task automatic send(input logic [C*W-1:0] f, input logic fst, input logic lst);
      logic rd;
      logic taken;
      taken = 1'b0;
      while (!taken) begin
         @(negedge clk);
         out_ready = (($urandom % 100) >= bp_pct);
         if (($urandom % 100) < gap_pct) begin
            in_valid = 1'b0;               // R7: idle gap
         end else begin
            in_valid = 1'b1;
            in_feat  = f;
            in_first = fst;
            in_last  = lst;
         end
         #1 rd = in_ready;
         @(posedge clk);
         taken = in_valid && rd;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid  = 1'b0;
         out_ready = (($urandom % 100) >= bp_pct);
      end
   endtask

   task automatic drain();
      for (int i = 0; i < 3 * K + 4; i++) begin
         @(negedge clk);
         in_valid  = 1'b0;
         out_ready = 1'b1;
      end
   endtask

   // R6: filter load only while the row is empty
   task automatic load_filters(input bit extreme);
      for (int k = 0; k < K; k++) begin
         for (int p = 0; p < MAXPOS; p++) begin
            @(negedge clk);
            flt_we   = 1'b1;
            flt_pe   = KSW'(k);
            flt_pos  = PSW'(p);
            flt_data = extreme ? {C{1'b1, {(W-1){1'b0}}}} : rnd_vec();
         end
      end
      @(negedge clk);
      flt_we = 1'b0;
   endtask

   task automatic group(input int len, input bit extreme);
      for (int i = 0; i < len; i++)
         send(extreme ? {C{1'b1, {(W-1){1'b0}}}} : rnd_vec(), i == 0, i == len - 1);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      repeat (4) @(negedge clk);
      rst_n = 1'b1;                          // R1 checked during reset above
      load_filters(1'b0);
      // R2 R4: plain groups, no gaps
      for (int g = 0; g < 6; g++) group(1 + ($urandom % MAXPOS), 1'b0);
      drain();
      // R7: random input gaps
      gap_pct = 40;
      for (int g = 0; g < 10; g++) group(1 + ($urandom % MAXPOS), 1'b0);
      drain();
      // R9 R10: output back-pressure with gaps
      bp_pct = 50;
      for (int g = 0; g < 12; g++) group(1 + ($urandom % MAXPOS), 1'b0);
      idle(20);
      drain();
      // R8 R11: back-to-back single-vector groups
      gap_pct = 0; bp_pct = 0;
      for (int g = 0; g < 20; g++) group(1, 1'b0);
      bp_pct = 30;
      for (int g = 0; g < 20; g++) group(1, 1'b0);
      drain();
      // R5: partial groups aborted by a fresh first
      bp_pct = 20; gap_pct = 20;
      for (int g = 0; g < 8; g++) begin
         int part;
         part = 1 + ($urandom % (MAXPOS - 1));
         for (int i = 0; i < part; i++) send(rnd_vec(), i == 0, 1'b0);
         group(1 + ($urandom % MAXPOS), 1'b0);
      end
      drain();
      // R3: widest sums, most negative values over MAXPOS positions
      gap_pct = 0; bp_pct = 0;
      load_filters(1'b1);
      group(MAXPOS, 1'b1);
      group(MAXPOS, 1'b1);
      drain();
      // R6: reload and confirm new weights take effect
      load_filters(1'b0);
      for (int g = 0; g < 6; g++) group(1 + ($urandom % MAXPOS), 1'b0);
      drain();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule